// File: doc/BRIEF.md
# Set/Clear/Toggle Alias Register Bank

This block is a window of 32-bit control registers on a simple word-wide bus. The bus carries a byte offset, and the block derives the word index from it by dropping the two low bits. The window has two regions. A plain region at the bottom holds ordinary storage words. An aliased region starts at a fixed higher offset. In the aliased region, a parameter list names a set of base words. Each base owns the three words directly above it, and software can use those three words to modify the base without a read-modify-write.

A write to a base word stores the data as given. A write one word above the base ORs the data in. A write two words above clears the base bits that are 1 in the data. A write three words above inverts those bits. A read of any of the three shadow words returns the base. Words in the aliased region that are neither a base nor a shadow act as plain storage.

Some base registers stand for PLL controls. Those get a reset value with a lock status bit forced high. Each accepted request is answered exactly one cycle later. Accesses that miss both regions, and misaligned accesses, answer zero, change nothing and raise an error strobe.

Top module: `sct_reg_bank`

## Requirements
- R1: After reset, each aliased base reads its parameterised reset value. For each base marked as a PLL control, bit 31 (the lock bit) is also forced to 1. Every other word reads zero.
- R2: In both regions, a write to a word that is not a shadow replaces the whole word, and a later read returns it.
- R3: A write to byte offset 0x4000 + 4*(base+1) ORs the data into the base word.
- R4: A write to byte offset 0x4000 + 4*(base+2) clears each base bit that is 1 in the data and keeps the others.
- R5: A write to byte offset 0x4000 + 4*(base+3) inverts each base bit that is 1 in the data.
- R6: A read at any of the three shadow offsets of a base returns the current base value.
- R7: A read issued in the cycle directly after a shadow write returns the updated base value.
- R8: Every request cycle gets exactly one response cycle one clock later (rsp_valid high). For reads, rsp_rdata carries the data. For writes, rsp_rdata is zero. With no request, rsp_valid and rsp_err stay low.
- R9: A byte offset outside both [0, 4*PLAIN_WORDS) and [0x4000, 0x4000+4*ALIAS_WORDS) gets the following response: rsp_rdata 0, rsp_err high for that one response cycle, and no stored word changes. This includes offsets at or above the 0x5000-byte window.
- R10: An offset with bits [1:0] not zero is treated as in R9, even when it would otherwise hit a shadow word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Byte offset inside the window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | 32 | Read data, zero for writes and errors |
| rsp_err | output | 1 | Response is for a missed or misaligned access |

## Verification
The assertions take for granted that at most one request is presented per cycle and that req_addr and req_write are settled whenever req_valid is high. The bench changes its inputs only on the falling edge and presents each request for exactly one cycle. Requests are issued back to back or separated by idle cycles with req_valid low. The stimulus stays on the default parameter set, where the bases sit at aliased words 0, 4, 8 and 12 and so do not overlap.

// File: rtl/sct_pkg.sv
package sct_pkg;

    localparam int WORD_W = 32;

    typedef logic [WORD_W-1:0] word_t;

    // Offset of the accessed word above its base selects the operation.
    typedef enum logic [1:0] {
        OP_PUT  = 2'd0,
        OP_OR   = 2'd1,
        OP_ANDN = 2'd2,
        OP_XOR  = 2'd3
    } alias_op_e;

    function automatic word_t merge_word(alias_op_e op, word_t cur, word_t wd);
        case (op)
            OP_OR:   return cur | wd;
            OP_ANDN: return cur & ~wd;
            OP_XOR:  return cur ^ wd;
            default: return wd;
        endcase
    endfunction

endpackage

// File: rtl/sct_decode.sv
module sct_decode
    import sct_pkg::*;
#(
    parameter int unsigned ADDR_W       = 15,
    parameter int unsigned PLAIN_WORDS  = 8,
    parameter int unsigned ALIAS_WORDS  = 20,
    parameter int unsigned ALIAS_OFFSET = 'h4000,
    parameter int unsigned NUM_SET      = 4,
    parameter int unsigned SET_BASE [NUM_SET] = '{0, 4, 8, 12},
    localparam int unsigned PIDX_W      = $clog2(PLAIN_WORDS),
    localparam int unsigned AIDX_W      = $clog2(ALIAS_WORDS)
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              plain_hit,
    output logic              alias_hit,
    output logic              bad,
    output logic [PIDX_W-1:0] plain_idx,
    output logic [AIDX_W-1:0] alias_idx,
    output alias_op_e         op
);

    localparam int unsigned PLAIN_END = PLAIN_WORDS * 4;
    localparam int unsigned ALIAS_END = ALIAS_OFFSET + ALIAS_WORDS * 4;

    logic [31:0]              addr_ext;
    logic [31:0]              aword;
    logic                     aligned;
    logic                     in_plain;
    logic                     in_alias;
    logic [NUM_SET-1:0]       match;
    logic [NUM_SET-1:0][1:0]  offs;

    assign addr_ext = 32'(addr);
    assign aligned  = (addr[1:0] == 2'b00);
    assign in_plain = (addr_ext < PLAIN_END);
    assign in_alias = (addr_ext >= ALIAS_OFFSET) && (addr_ext < ALIAS_END);
    assign aword    = (addr_ext - 32'(ALIAS_OFFSET)) >> 2;

    // One window comparator per aliased base.
    for (genvar k = 0; k < NUM_SET; k++) begin : g_set
        assign match[k] = in_alias && (aword >= SET_BASE[k]) && (aword < SET_BASE[k] + 4);
        assign offs[k]  = 2'(aword - SET_BASE[k]);
    end

    always_comb begin
        alias_idx = AIDX_W'(aword);
        op        = OP_PUT;
        for (int k = 0; k < NUM_SET; k++) begin
            if (match[k]) begin
                alias_idx = AIDX_W'(SET_BASE[k]);
                op        = alias_op_e'(offs[k]);
            end
        end
        plain_idx = PIDX_W'(addr_ext >> 2);
        plain_hit = aligned && in_plain;
        alias_hit = aligned && in_alias;
        bad       = !(plain_hit || alias_hit);
    end

endmodule

// File: rtl/sct_plain_bank.sv
module sct_plain_bank
    import sct_pkg::*;
#(
    parameter int unsigned WORDS    = 8,
    parameter word_t       RST_FILL = '0,
    localparam int unsigned IDX_W   = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  word_t            wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output word_t            rd_data
);

    typedef struct packed {
        logic [WORDS-1:0][WORD_W-1:0] mem;
    } plain_st_t;

    plain_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.mem[wr_idx] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mem <= {WORDS{RST_FILL}};
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data = st_q.mem[rd_idx];

endmodule

// File: rtl/sct_alias_bank.sv
module sct_alias_bank
    import sct_pkg::*;
#(
    parameter int unsigned WORDS    = 20,
    parameter int unsigned NUM_SET  = 4,
    parameter int unsigned SET_BASE [NUM_SET] = '{0, 4, 8, 12},
    parameter word_t       SET_RST  [NUM_SET] = '{32'h0001_3042, 32'h0001_2000,
                                                  32'h0001_3001, 32'h1018_101B},
    parameter logic [NUM_SET-1:0] PLL_MASK = 4'b0111,
    parameter int unsigned LOCK_BIT = 31,
    localparam int unsigned IDX_W   = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  alias_op_e        wr_op,
    input  word_t            wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output word_t            rd_data
);

    typedef logic [WORDS-1:0][WORD_W-1:0] image_t;

    typedef struct packed {
        image_t mem;
    } alias_st_t;

    // Reset image: base values first, then lock bit forced for PLL bases.
    function automatic image_t reset_image();
        image_t img = '0;
        for (int k = 0; k < NUM_SET; k++) begin
            img[SET_BASE[k]] = SET_RST[k];
            if (PLL_MASK[k]) begin
                img[SET_BASE[k]][LOCK_BIT] = 1'b1;
            end
        end
        return img;
    endfunction

    localparam image_t RESET_IMAGE = reset_image();

    alias_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.mem[wr_idx] = merge_word(wr_op, st_q.mem[wr_idx], wr_data);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mem <= RESET_IMAGE;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data = st_q.mem[rd_idx];

endmodule

// File: rtl/sct_reg_bank.sv
module sct_reg_bank
    import sct_pkg::*;
#(
    parameter int unsigned WINDOW_BYTES = 'h5000,
    parameter int unsigned ALIAS_OFFSET = 'h4000,
    parameter int unsigned PLAIN_WORDS  = 8,
    parameter int unsigned ALIAS_WORDS  = 20,
    parameter int unsigned NUM_SET      = 4,
    parameter int unsigned SET_BASE [NUM_SET] = '{0, 4, 8, 12},
    parameter logic [31:0] SET_RST  [NUM_SET] = '{32'h0001_3042, 32'h0001_2000,
                                                  32'h0001_3001, 32'h1018_101B},
    parameter logic [NUM_SET-1:0] PLL_MASK = 4'b0111,
    parameter int unsigned LOCK_BIT     = 31,
    localparam int unsigned ADDR_W      = $clog2(WINDOW_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic              rsp_err
);

    localparam int unsigned PIDX_W = $clog2(PLAIN_WORDS);
    localparam int unsigned AIDX_W = $clog2(ALIAS_WORDS);

    typedef struct packed {
        logic  valid;
        logic  err;
        word_t rdata;
    } rsp_t;

    logic              plain_hit;
    logic              alias_hit;
    logic              bad;
    logic [PIDX_W-1:0] plain_idx;
    logic [AIDX_W-1:0] alias_idx;
    alias_op_e         op;
    word_t             plain_rd;
    word_t             alias_rd;
    logic              plain_we;
    logic              alias_we;
    rsp_t              rsp_d, rsp_q;

    sct_decode #(
        .ADDR_W      (ADDR_W),
        .PLAIN_WORDS (PLAIN_WORDS),
        .ALIAS_WORDS (ALIAS_WORDS),
        .ALIAS_OFFSET(ALIAS_OFFSET),
        .NUM_SET     (NUM_SET),
        .SET_BASE    (SET_BASE)
    ) i_decode (
        .addr     (req_addr),
        .plain_hit(plain_hit),
        .alias_hit(alias_hit),
        .bad      (bad),
        .plain_idx(plain_idx),
        .alias_idx(alias_idx),
        .op       (op)
    );

    sct_plain_bank #(
        .WORDS   (PLAIN_WORDS),
        .RST_FILL('0)
    ) i_plain (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (plain_we),
        .wr_idx (plain_idx),
        .wr_data(req_wdata),
        .rd_idx (plain_idx),
        .rd_data(plain_rd)
    );

    sct_alias_bank #(
        .WORDS   (ALIAS_WORDS),
        .NUM_SET (NUM_SET),
        .SET_BASE(SET_BASE),
        .SET_RST (SET_RST),
        .PLL_MASK(PLL_MASK),
        .LOCK_BIT(LOCK_BIT)
    ) i_alias (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (alias_we),
        .wr_idx (alias_idx),
        .wr_op  (op),
        .wr_data(req_wdata),
        .rd_idx (alias_idx),
        .rd_data(alias_rd)
    );

    always_comb begin
        plain_we    = req_valid && req_write && plain_hit;
        alias_we    = req_valid && req_write && alias_hit;
        rsp_d.valid = req_valid;
        rsp_d.err   = req_valid && bad;
        rsp_d.rdata = '0;
        if (req_valid && !req_write) begin
            if (plain_hit) begin
                rsp_d.rdata = plain_rd;
            end else if (alias_hit) begin
                rsp_d.rdata = alias_rd;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_err   = rsp_q.err;
    assign rsp_rdata = rsp_q.rdata;

endmodule

// File: rtl/sct_reg_bank_chk.sv
module sct_reg_bank_chk #(
    parameter int unsigned ADDR_W       = 15,
    parameter int unsigned WINDOW_BYTES = 'h5000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic              rsp_valid,
    input logic [31:0]       rsp_rdata,
    input logic              rsp_err
);

    assert_rsp_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && !rsp_err));

    assert_write_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |=> (rsp_rdata == 32'h0));

    assert_err_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_valid && rsp_rdata == 32'h0));

    assert_window_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && 32'(req_addr) >= WINDOW_BYTES) |=> rsp_err);

    assert_misaligned_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr[1:0] != 2'b00) |=> rsp_err);

endmodule

bind sct_reg_bank sct_reg_bank_chk #(
    .ADDR_W      (ADDR_W),
    .WINDOW_BYTES(WINDOW_BYTES)
) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_write(req_write),
    .req_addr (req_addr),
    .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata),
    .rsp_err  (rsp_err)
);

// File: tb/test_sct_reg_bank.sv
module test_sct_reg_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [14:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        rsp_err;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    sct_reg_bank i_sct_reg_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_write(req_write),
        .req_addr (req_addr),
        .req_wdata(req_wdata),
        .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata),
        .rsp_err  (rsp_err)
    );

    typedef struct {
        logic [31:0] rdata;
        logic        err;
        string       tag;
    } exp_t;

    exp_t exp_q[$];

    // Reference model built from the requirements.
    logic [31:0] m_plain [8];
    logic [31:0] m_alias [20];

    function automatic logic [14:0] sh(int base, int op);
        return 15'('h4000 + (base + op) * 4);
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 8; i++) m_plain[i] = '0;
        for (int i = 0; i < 20; i++) m_alias[i] = '0;
        m_alias[0]  = 32'h8001_3042;
        m_alias[4]  = 32'h8001_2000;
        m_alias[8]  = 32'h8001_3001;
        m_alias[12] = 32'h1018_101B;
    endtask

    task automatic bus(input bit wr, input logic [14:0] a, input logic [31:0] d, input string tag);
        exp_t e;
        int   w;
        int   base;
        int   op;
        e.rdata = '0;
        e.err   = 1'b0;
        e.tag   = tag;
        if (a[1:0] != 2'b00) begin
            e.err = 1'b1;
        end else if (a < 15'd32) begin
            if (wr) m_plain[a >> 2] = d;
            else    e.rdata = m_plain[a >> 2];
        end else if (a >= 15'h4000 && a < 15'h4050) begin
            w    = (int'(a) - 'h4000) >> 2;
            base = w;
            op   = 0;
            if (w < 16) begin
                base = w & ~3;
                op   = w & 3;
            end
            if (wr) begin
                case (op)
                    1: m_alias[base] = m_alias[base] | d;
                    2: m_alias[base] = m_alias[base] & ~d;
                    3: m_alias[base] = m_alias[base] ^ d;
                    default: m_alias[base] = d;
                endcase
            end else begin
                e.rdata = m_alias[base];
            end
        end else begin
            e.err = 1'b1;
        end
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        exp_q.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
            req_write = 1'b0;
            req_addr  = '0;
            req_wdata = '0;
        end
    endtask

    // Monitor: pop one expectation per response.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            exp_t e;
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R8 unexpected response: actual rdata=%h err=%b, expected none",
                         rsp_rdata, rsp_err);
            end else begin
                e = exp_q.pop_front();
                if (rsp_rdata !== e.rdata || rsp_err !== e.err) begin
                    fails++;
                    $display("FAIL %s: actual rdata=%h err=%b, expected rdata=%h err=%b",
                             e.tag, rsp_rdata, rsp_err, e.rdata, e.err);
                end
            end
        end
    end

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout, expected completion");
        finish_run();
    end

    initial begin
        model_reset();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b0 || rsp_err !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset outputs: actual valid=%b err=%b, expected 0 0", rsp_valid, rsp_err);
        end

        // R1: reset image with forced lock bits
        bus(0, sh(0, 0),  0, "R1 base0 reset");
        bus(0, sh(4, 0),  0, "R1 base4 reset");
        bus(0, sh(8, 0),  0, "R1 base8 reset");
        bus(0, sh(12, 0), 0, "R1 base12 unlocked reset");
        bus(0, 15'h0000,  0, "R1 plain reset");
        bus(0, sh(16, 0), 0, "R1 aliased-region plain reset");
        idle(2);

        // R2: plain storage in both regions
        bus(1, 15'h000C, 32'hA5A5_5A5A, "R2 plain write");
        bus(0, 15'h000C, 0, "R2 plain read");
        bus(1, sh(17, 0), 32'h1234_5678, "R2 aliased-region plain write");
        idle(1);
        bus(0, sh(17, 0), 0, "R2 aliased-region plain read");
        bus(1, sh(0, 0), 32'h0F0F_0000, "R2 base write");
        bus(0, sh(0, 0), 0, "R2 base readback");

        // R3/R4/R5/R7 on three bases, each read directly after the shadow write
        for (int b = 0; b < 12; b += 4) begin
            bus(1, sh(b, 0), 32'h00FF_00F0, "R2 base load");
            bus(1, sh(b, 1), 32'hF000_000F, "R3 set write");
            bus(0, sh(b, 0), 0, "R3 R7 set result");
            bus(1, sh(b, 2), 32'h00F0_00FF, "R4 clear write");
            bus(0, sh(b, 0), 0, "R4 R7 clear result");
            bus(1, sh(b, 3), 32'hFFFF_0000, "R5 toggle write");
            bus(0, sh(b, 0), 0, "R5 R7 toggle result");
            // R6: every shadow reads the base
            bus(0, sh(b, 1), 0, "R6 set shadow read");
            bus(0, sh(b, 2), 0, "R6 clear shadow read");
            bus(0, sh(b, 3), 0, "R6 toggle shadow read");
            idle(1);
        end
        // toggle twice restores; clear of lock bit
        bus(1, sh(12, 3), 32'h8000_0001, "R5 toggle base12");
        bus(1, sh(12, 3), 32'h8000_0001, "R5 toggle back");
        bus(0, sh(12, 0), 0, "R5 double toggle");

        // R9: misses read zero, error, and change nothing
        bus(0, 15'h0020, 0, "R9 gap after plain read");
        bus(1, 15'h0020, 32'hFFFF_FFFF, "R9 gap write");
        bus(0, 15'h001C, 0, "R9 neighbour plain unchanged");
        bus(0, 15'h4050, 0, "R9 past aliased region");
        bus(1, 15'h4FFC, 32'hFFFF_FFFF, "R9 window tail write");
        bus(0, sh(19, 0), 0, "R9 last aliased word unchanged");
        bus(0, 15'h5000, 0, "R9 outside window");
        bus(1, 15'h7FFC, 32'h1, "R9 top address write");
        bus(0, 15'h3FFC, 0, "R9 below aliased region");

        // R10: misaligned shadow write is rejected
        bus(1, 15'h4005, 32'hFFFF_FFFF, "R10 misaligned set write");
        bus(0, sh(0, 0), 0, "R10 base0 unchanged");
        bus(0, 15'h0002, 0, "R10 misaligned plain read");
        idle(4);

        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R8 missing responses: actual %0d pending, expected 0", exp_q.size());
        end
        finish_run();
    end

endmodule